// File: doc/BRIEF.md
# Host-to-Core Transmit Channel

This block carries 24-bit words from an external host processor to a core-side receive register. The host writes a word one byte at a time into three transmit latches, selected by a two-bit address: 0 is the high byte, 1 the middle byte and 2 the low byte. One of these writes is the completing write, and an endianness control selects which byte that is. Once a word is complete and the core-side register is empty, the word moves into the register and the core reads it with a single read strobe.

The host polls an 8-bit status byte. It shows whether the latches are empty and whether the whole path is idle. It also shows two flags that only the core can write, and the state of the request outputs. The request outputs come in two modes. In split mode there is one transmit request pin and one receive request pin. In combined mode a single pin carries both. An initialize pulse marks the latches empty and drops any word that has not yet moved.

Top module: `hxc_host_tx_chan`

## Requirements
- R1: After reset the status byte reads 0x06, the core-side register is empty, its data is zero, the core flags read 0 and all three request outputs are low.
- R2: A host write to address 0 or 1 when `ctl_hi_last`=0, or to address 1 or 2 when `ctl_hi_last`=1, updates only that byte latch and changes no status bit. A write to address 3 has no effect.
- R3: The completing write goes to address 2 (low byte) when `ctl_hi_last`=0 and to address 0 (high byte) when `ctl_hi_last`=1. If the core-side register is full, this write clears status bit 1 (latch empty) at the next edge.
- R4: A word moves into the core-side register at any edge where the register is empty, no initialize is present, and either a word is pending or a completing write arrives. At that edge `core_full` rises, `core_data` takes {high, middle, low} including the byte being written, and status bit 1 stays or becomes 1.
- R5: A core read strobe while the register is full clears `core_full` at that edge. A pending word moves at the following edge.
- R6: A host initialize pulse sets status bit 1 at that edge and discards any pending word. The discarded word is never delivered.
- R7: Status bit 2 (transmitter ready) is 1 exactly when status bit 1 is 1 and the core-side register is empty. In that state a completing write reaches `core_data` at the same edge.
- R8: Status bits 3 and 4 show core flags 0 and 1. These flags load from `core_hf_d` when `core_hf_we` is high. Status bits 0, 5 and 6 always read 0.
- R9: With `ctl_dual`=1, `req_tx` is `ctl_treq_en` AND the latch-empty flag, `req_rx` is `ctl_rreq_en` AND `rx_has_data`, `req_host` is 0, and status bit 7 is `req_tx` OR `req_rx`. All are registered from the values at the edge.
- R10: With `ctl_dual`=0, `req_host` is (`ctl_treq_en` AND latch-empty) OR (`ctl_rreq_en` AND `rx_has_data`), `req_tx` and `req_rx` are 0, and status bit 7 equals `req_host`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | 2 | Byte select: 0 high, 1 middle, 2 low |
| host_wdata | input | 8 | Host write byte |
| host_init | input | 1 | Initialize pulse: marks latches empty |
| ctl_hi_last | input | 1 | 1: high byte completes a word; 0: low byte |
| ctl_treq_en | input | 1 | Transmit request enable |
| ctl_rreq_en | input | 1 | Receive request enable |
| ctl_dual | input | 1 | 1: split request pins; 0: combined pin |
| rx_has_data | input | 1 | Receive-direction data waiting for the host |
| core_hf_we | input | 1 | Core flag write strobe |
| core_hf_d | input | 2 | Core flag values |
| core_rd | input | 1 | Core read strobe of the receive register |
| core_data | output | 24 | Core-side receive register |
| core_full | output | 1 | Core-side receive register holds a word |
| status | output | 8 | Host-readable status byte |
| req_tx | output | 1 | Transmit request (split mode) |
| req_rx | output | 1 | Receive request (split mode) |
| req_host | output | 1 | Combined request (single mode) |

## Verification
The hardest cases to reach from the ports are a completing write, an initialize pulse or a core read landing on the same edge as a pending transfer. Each of these happens only while a word waits behind a full core-side register. The random stimulus keeps read strobes sparse so that words back up often. It also draws initialize pulses and completing-byte writes in the same cycles as those reads, and flips the endianness control in the middle of a run. Directed steps first place the pass-through, blocked-write, read-then-move and discard cases one after another, before the random phase starts.

// File: rtl/hxc_pkg.sv
package hxc_pkg;

  // index of the latch whose write completes a word
  function automatic int cmpl_index(input logic hi_last, input int n_bytes);
    return hi_last ? 0 : n_bytes - 1;
  endfunction

  // status bit 7 source selection
  function automatic logic req_summary(input logic dual, input logic rt,
                                       input logic rr, input logic rh);
    return dual ? (rt | rr) : rh;
  endfunction

  // host status byte layout
  function automatic logic [7:0] pack_status(input logic txde, input logic full,
                                             input logic [1:0] hf, input logic req);
    return {req, 2'b00, hf[1], hf[0], txde & ~full, txde, 1'b0};
  endfunction

endpackage

// File: rtl/hxc_tx_latch.sv
module hxc_tx_latch #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  localparam int ADDR_W = (N_BYTES > 1) ? $clog2(N_BYTES + 1) : 1,
  localparam int WORD_W = BYTE_W * N_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              hi_last,
  input  logic              init,
  input  logic              core_full,
  output logic [WORD_W-1:0] merged_word,
  output logic              txde_q,
  output logic              txde_d,
  output logic              wr_complete,
  output logic              xfer_load
);
  import hxc_pkg::*;

  logic [N_BYTES-1:0][BYTE_W-1:0] byte_q;
  logic [N_BYTES-1:0][BYTE_W-1:0] byte_d;

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    assign byte_d[i] = (wr && addr == ADDR_W'(i)) ? wdata : byte_q[i];
    assign merged_word[WORD_W-1-i*BYTE_W -: BYTE_W] = byte_d[i];
  end

  assign wr_complete = wr && (addr == ADDR_W'(cmpl_index(hi_last, N_BYTES)));
  assign xfer_load   = !core_full && !init && (!txde_q || wr_complete);

  always_comb begin
    txde_d = txde_q;
    if (init)             txde_d = 1'b1;
    else if (xfer_load)   txde_d = 1'b1;
    else if (wr_complete) txde_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      txde_q <= 1'b1;
    end else begin
      byte_q <= byte_d;
      txde_q <= txde_d;
    end
  end

endmodule

// File: rtl/hxc_rx_reg.sv
module hxc_rx_reg #(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              rd,
  output logic [WORD_W-1:0] data_q,
  output logic              full_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      data_q <= load_word;
      full_q <= 1'b1;
    end else if (rd) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/hxc_req_gen.sv
module hxc_req_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic dual,
  input  logic treq_en,
  input  logic rreq_en,
  input  logic tx_cond,
  input  logic rx_cond,
  output logic req_tx,
  output logic req_rx,
  output logic req_host
);
  logic tx_want, rx_want;
  assign tx_want = treq_en & tx_cond;
  assign rx_want = rreq_en & rx_cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_tx   <= 1'b0;
      req_rx   <= 1'b0;
      req_host <= 1'b0;
    end else begin
      req_tx   <= dual & tx_want;
      req_rx   <= dual & rx_want;
      req_host <= ~dual & (tx_want | rx_want);
    end
  end
endmodule

// File: rtl/hxc_host_tx_chan.sv
module hxc_host_tx_chan #(
  parameter int BYTE_W  = 8,
  parameter int N_BYTES = 3,
  localparam int ADDR_W = (N_BYTES > 1) ? $clog2(N_BYTES + 1) : 1,
  localparam int WORD_W = BYTE_W * N_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_init,
  input  logic              ctl_hi_last,
  input  logic              ctl_treq_en,
  input  logic              ctl_rreq_en,
  input  logic              ctl_dual,
  input  logic              rx_has_data,
  input  logic              core_hf_we,
  input  logic [1:0]        core_hf_d,
  input  logic              core_rd,
  output logic [WORD_W-1:0] core_data,
  output logic              core_full,
  output logic [7:0]        status,
  output logic              req_tx,
  output logic              req_rx,
  output logic              req_host
);
  import hxc_pkg::*;

  logic [WORD_W-1:0] merged_word;
  logic              txde_q, txde_d;
  logic              wr_complete, xfer_load;
  logic [1:0]        hf_q;

  hxc_tx_latch #(.BYTE_W(BYTE_W), .N_BYTES(N_BYTES)) u_latch (
    .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr), .wdata(host_wdata),
    .hi_last(ctl_hi_last), .init(host_init), .core_full(core_full),
    .merged_word(merged_word), .txde_q(txde_q), .txde_d(txde_d),
    .wr_complete(wr_complete), .xfer_load(xfer_load)
  );

  hxc_rx_reg #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .load(xfer_load), .load_word(merged_word),
    .rd(core_rd), .data_q(core_data), .full_q(core_full)
  );

  hxc_req_gen u_req (
    .clk(clk), .rst_n(rst_n), .dual(ctl_dual), .treq_en(ctl_treq_en),
    .rreq_en(ctl_rreq_en), .tx_cond(txde_d), .rx_cond(rx_has_data),
    .req_tx(req_tx), .req_rx(req_rx), .req_host(req_host)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hf_q <= 2'b00;
    else if (core_hf_we) hf_q <= core_hf_d;
  end

  assign status = pack_status(txde_q, core_full, hf_q,
                              req_summary(ctl_dual, req_tx, req_rx, req_host));

endmodule

// File: rtl/hxc_host_tx_chan_chk.sv
module hxc_host_tx_chan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_wr,
  input logic       host_init,
  input logic       core_rd,
  input logic       ctl_dual,
  input logic       wr_complete,
  input logic       xfer_load,
  input logic       core_full,
  input logic [7:0] status,
  input logic       req_tx,
  input logic       req_rx,
  input logic       req_host
);
  AST_TRDY_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    status[2] |-> (status[1] && !core_full)); // R7

  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (status[6:5] == 2'b00) && !status[0]); // R8

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_load |=> (core_full && status[1])); // R4

  AST_BLOCKED_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_complete && core_full && !host_init) |=> !status[1]); // R3

  AST_INIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    host_init |=> status[1]); // R6

  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && core_full) |=> !core_full); // R5

  AST_PARTIAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !wr_complete && !host_init && !xfer_load) |=> (status[1] == $past(status[1]))); // R2

  AST_DUAL_NO_JOINT: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_dual |=> !req_host); // R9

  AST_JOINT_NO_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_dual |=> (!req_tx && !req_rx)); // R10
endmodule

bind hxc_host_tx_chan hxc_host_tx_chan_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_init(host_init),
  .core_rd(core_rd), .ctl_dual(ctl_dual), .wr_complete(wr_complete),
  .xfer_load(xfer_load), .core_full(core_full), .status(status),
  .req_tx(req_tx), .req_rx(req_rx), .req_host(req_host)
);

// File: tb/hxc_host_tx_chan_tb.sv
`timescale 1ns/1ps
module hxc_host_tx_chan_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_init = 0, ctl_hi_last = 0, ctl_treq_en = 0, ctl_rreq_en = 0;
  logic ctl_dual = 0, rx_has_data = 0, core_hf_we = 0, core_rd = 0;
  logic [1:0] host_addr = 0;
  logic [7:0] host_wdata = 0;
  logic [1:0] core_hf_d = 0;
  logic [23:0] core_data;
  logic core_full, req_tx, req_rx, req_host;
  logic [7:0] status;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_b [3];
  logic m_txde = 1, m_full = 0, m_rt = 0, m_rr = 0, m_rh = 0;
  logic [23:0] m_data = 0;
  logic [1:0] m_hf = 0;

  always #2.5 clk = ~clk;

  hxc_host_tx_chan u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_init(host_init), .ctl_hi_last(ctl_hi_last),
    .ctl_treq_en(ctl_treq_en), .ctl_rreq_en(ctl_rreq_en), .ctl_dual(ctl_dual),
    .rx_has_data(rx_has_data), .core_hf_we(core_hf_we), .core_hf_d(core_hf_d),
    .core_rd(core_rd), .core_data(core_data), .core_full(core_full),
    .status(status), .req_tx(req_tx), .req_rx(req_rx), .req_host(req_host)
  );

  function automatic logic [7:0] exp_status();
    logic b7;
    b7 = ctl_dual ? (m_rt | m_rr) : m_rh;
    return {b7, 2'b00, m_hf[1], m_hf[0], m_txde & ~m_full, m_txde, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // advance the model by one edge using the inputs held for that edge
  task automatic model_edge();
    logic cmpl, load;
    cmpl = host_wr && (host_addr == (ctl_hi_last ? 2'd0 : 2'd2));
    if (host_wr && host_addr != 2'd3) m_b[host_addr] = host_wdata;
    load = !m_full && !host_init && (!m_txde || cmpl);
    if (load) begin
      m_data = {m_b[0], m_b[1], m_b[2]};
      m_full = 1;
    end else if (core_rd) m_full = 0;
    if (host_init) m_txde = 1;
    else if (load) m_txde = 1;
    else if (cmpl) m_txde = 0;
    if (core_hf_we) m_hf = core_hf_d;
    m_rt = ctl_dual & ctl_treq_en & m_txde;
    m_rr = ctl_dual & ctl_rreq_en & rx_has_data;
    m_rh = !ctl_dual & ((ctl_treq_en & m_txde) | (ctl_rreq_en & rx_has_data));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R7 status", {24'd0, status}, {24'd0, exp_status()});
    chk("R4 core_full", {31'd0, core_full}, {31'd0, m_full});
    chk("R4 core_data", {8'd0, core_data}, {8'd0, m_data});
    chk("R9 req_tx/req_rx", {30'd0, req_tx, req_rx}, {30'd0, m_rt, m_rr});
    chk("R10 req_host", {31'd0, req_host}, {31'd0, m_rh});
    host_wr = 0; host_init = 0; core_rd = 0; core_hf_we = 0;
  endtask

  task automatic hwrite(input logic [1:0] a, input logic [7:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    step();
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 3; i++) m_b[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", {24'd0, status}, 32'h06);
    chk("R1 core_full", {31'd0, core_full}, 0);
    chk("R1 core_data", {8'd0, core_data}, 0);
    chk("R1 requests", {29'd0, req_tx, req_rx, req_host}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 partial writes keep flags; R7 pass-through on completing low byte
    hwrite(2'd0, 8'hA1);
    hwrite(2'd1, 8'hB2);
    chk("R2 txde kept", {31'd0, status[1]}, 1);
    chk("R2 no transfer", {31'd0, core_full}, 0);
    hwrite(2'd3, 8'hFF);
    chk("R2 addr3 ignored", {31'd0, status[1]}, 1);
    hwrite(2'd2, 8'hC3);
    chk("R7 pass-through data", {8'd0, core_data}, 32'hA1B2C3);
    chk("R7 trdy drops", {31'd0, status[2]}, 0);

    // R3 blocked completing write
    hwrite(2'd0, 8'h11);
    chk("R3 txde still set", {31'd0, status[1]}, 1);
    hwrite(2'd2, 8'h33);
    chk("R3 txde cleared", {31'd0, status[1]}, 0);
    // R5 read then move
    core_rd = 1; step();
    chk("R5 full cleared", {31'd0, core_full}, 0);
    step();
    chk("R5 pending moved", {8'd0, core_data}, 32'h11B233);
    chk("R5 txde set", {31'd0, status[1]}, 1);

    // R6 initialize discards pending
    hwrite(2'd2, 8'h44);
    host_init = 1; step();
    chk("R6 txde forced", {31'd0, status[1]}, 1);
    core_rd = 1; step();
    step();
    chk("R6 discarded", {31'd0, core_full}, 0);

    // R3 high byte completes when ctl_hi_last=1
    ctl_hi_last = 1;
    hwrite(2'd2, 8'h55);
    chk("R3 low not completing", {31'd0, core_full}, 0);
    hwrite(2'd0, 8'h66);
    chk("R3 high completes", {8'd0, core_data}, 32'h66B255);

    // R8 core flags, R9/R10 request modes
    core_hf_we = 1; core_hf_d = 2'b10; step();
    chk("R8 flags", {30'd0, status[4:3]}, 2);
    ctl_dual = 1; ctl_treq_en = 1; rx_has_data = 1; ctl_rreq_en = 1; step();
    chk("R9 split req", {29'd0, req_tx, req_rx, req_host}, 3'b110);
    ctl_dual = 0; ctl_treq_en = 0; step();
    chk("R10 combined req", {29'd0, req_tx, req_rx, req_host}, 3'b001);
    chk("R10 bit7", {31'd0, status[7]}, 1);

    // random phase
    for (int k = 0; k < 4000; k++) begin
      host_wr     = ($urandom % 3) != 0;
      host_addr   = 2'($urandom);
      host_wdata  = 8'($urandom);
      host_init   = ($urandom % 23) == 0;
      core_rd     = ($urandom % 5) == 0;
      core_hf_we  = ($urandom % 11) == 0;
      core_hf_d   = 2'($urandom);
      rx_has_data = 1'($urandom);
      if ($urandom % 50 == 0) ctl_hi_last = ~ctl_hi_last;
      if ($urandom % 30 == 0) ctl_dual    = ~ctl_dual;
      if ($urandom % 20 == 0) ctl_treq_en = ~ctl_treq_en;
      if ($urandom % 20 == 0) ctl_rreq_en = ~ctl_rreq_en;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule